// File: doc/BRIEF.md
# JTAG Debug Register Access Port

This block is a JTAG test access port slave. It lets an external debugger reach a bank of 32-bit debug registers inside a chip. It also gives access to an 8-bit power control register and an 8-bit power status register. The port runs from the test clock. Its standard 16-state controller steps through the scans, and a 5-bit instruction register selects one of five data paths.

Debug register access takes two data scans under the register-select instruction. The first is an 8-bit address scan. Bits [7:1] carry a 7-bit register number, and bit 0 is the direction: 1 means write and 0 means read. The second is a 32-bit data scan. For a write, the shifted-in word goes to the register bus as a one-cycle write strobe at Update-DR. For a read, a one-cycle read strobe is issued at Capture-DR, and the returned word is shifted out least significant bit first.

The power status register collects status bits, which stay set once raised. When it is scanned, it returns its current value, and the byte shifted in at the same time is used as a mask that clears bits. Every scan in the bench returns to Run-Test/Idle.

Top module: `jtag_dbg_port`

## Requirements
- R1: Asserting trstN low, or five TCK cycles with TMS high, enters Test-Logic-Reset. This makes the identification code the current instruction, so a following 32-bit data scan shifts out IDCODE (default 32'h12345A6B), LSB first.
- R2: The instruction register is 5 bits. During Shift-IR it shifts out the captured pattern 5'b00001. The codes are: 0x08 power control, 0x09 power status, 0x1C register select, 0x1E identification, 0x1F bypass. Every other code acts as bypass.
- R3: Under register select, the first data scan after the instruction is loaded is 8 bits long and shifts out zeros. Its bits [7:1] set regNum, and its bit 0 is the direction (1 = write, 0 = read).
- R4: After a write address scan, the next 32-bit data scan raises regWrEn for exactly one TCK cycle in Update-DR. During that cycle regNum is the stored number and regWrData is the shifted-in word. The scan shifts out zeros.
- R5: After a read address scan, the next 32-bit data scan raises regRdEn for one cycle in Capture-DR and shifts out regRdData, LSB first. The bits shifted in are ignored: no write strobe follows.
- R6: A completed data scan returns register select to the address phase. Loading any instruction also returns it to the address phase, and in that case the pending access is dropped with no bus strobe.
- R7: The power control data register is 8 bits. A scan shifts out the previous value of pwrCtl, and Update-DR loads the shifted-in byte onto pwrCtl.
- R8: A power status bit is set by a high pwrStatSet bit and stays set. A status scan shifts out the current byte. At Update-DR, every bit that is 1 in the shifted-in byte is cleared.
- R9: The bypass register is 1 bit and captures 0. An 8-bit scan with input x therefore returns {x[6:0],0}.
- R10: tdo is 0 whenever the controller is in neither Shift-DR nor Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, LSB first |
| regWrEn | output | 1 | One-cycle register write strobe |
| regRdEn | output | 1 | One-cycle register read strobe |
| regNum | output | 7 | Register number from the address scan |
| regWrData | output | 32 | Word to write |
| regRdData | input | 32 | Word returned for regNum, combinational |
| pwrCtl | output | 8 | Power control register |
| pwrStatSet | input | 8 | Sets power status bits, one per bit |

## Verification
Counting from the falling edge that drives TMS high out of Run-Test/Idle, the results arrive at fixed points:
- The read strobe is seen at the second falling edge after that edge.
- The first captured bit is on tdo at the third falling edge.
- Each later shifted bit appears one TCK cycle after the one before it.
- The write strobe and a new pwrCtl value arrive at Update-DR, one and two cycles after Exit1-DR.

The bench drives TMS and TDI on falling edges and samples tdo, the strobes and pwrCtl on those same falling edges, half a cycle after the rising edge that changed them. The scan tasks push each expected bus transaction into a queue before the scan starts. A monitor pops one entry for every strobe it sees, and it flags any strobe for which no entry is waiting.

// File: rtl/jtag_dbg_pkg.sv
package jtag_dbg_pkg;

  localparam int IR_W = 5;
  localparam logic [IR_W-1:0] OP_PWR_CTL  = 5'h08;
  localparam logic [IR_W-1:0] OP_PWR_STAT = 5'h09;
  localparam logic [IR_W-1:0] OP_REG_SEL  = 5'h1C;
  localparam logic [IR_W-1:0] OP_IDCODE   = 5'h1E;
  localparam logic [IR_W-1:0] OP_BYPASS   = 5'h1F;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 5'b00001;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tapState_e;

  typedef enum logic [2:0] {
    DR_BYPASS, DR_IDCODE, DR_PCTL, DR_PSTAT, DR_REGSEL
  } drSel_e;

  typedef struct packed {
    logic   capDr;
    logic   shfDr;
    logic   updDr;
    drSel_e drSel;
    logic   dataPhase;
  } tapStrobe_t;

endpackage

// File: rtl/jtag_dbg_ctrl.sv
module jtag_dbg_ctrl
  import jtag_dbg_pkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  input  logic       tdi,
  output tapStrobe_t strb,
  output logic       irShifting,
  output logic       irTdo
);

  tapState_e state, nextState;
  logic [IR_W-1:0] irShift, irReg;
  logic dataPhase;
  drSel_e drSel;

  always_comb begin
    nextState = state;
    unique case (state)
      TS_RESET:  nextState = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   nextState = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: nextState = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: nextState = tms ? TS_EX1_DR : TS_SHF_DR;
      TS_SHF_DR: nextState = tms ? TS_EX1_DR : TS_SHF_DR;
      TS_EX1_DR: nextState = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: nextState = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: nextState = tms ? TS_UPD_DR : TS_SHF_DR;
      TS_UPD_DR: nextState = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: nextState = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: nextState = tms ? TS_EX1_IR : TS_SHF_IR;
      TS_SHF_IR: nextState = tms ? TS_EX1_IR : TS_SHF_IR;
      TS_EX1_IR: nextState = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: nextState = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: nextState = tms ? TS_UPD_IR : TS_SHF_IR;
      TS_UPD_IR: nextState = tms ? TS_SEL_DR : TS_IDLE;
      default:   nextState = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= TS_RESET;
    else        state <= nextState;
  end

  // Instruction register: capture, shift toward LSB, update
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= '0;
      irReg   <= OP_IDCODE;
    end else begin
      if (state == TS_RESET)       irReg   <= OP_IDCODE;
      else if (state == TS_UPD_IR) irReg   <= irShift;
      if (state == TS_CAP_IR)      irShift <= IR_CAPTURE;
      else if (state == TS_SHF_IR) irShift <= {tdi, irShift[IR_W-1:1]};
    end
  end

  always_comb begin
    unique case (irReg)
      OP_PWR_CTL:  drSel = DR_PCTL;
      OP_PWR_STAT: drSel = DR_PSTAT;
      OP_REG_SEL:  drSel = DR_REGSEL;
      OP_IDCODE:   drSel = DR_IDCODE;
      default:     drSel = DR_BYPASS;
    endcase
  end

  // Address/data phase flag for register select
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                                          dataPhase <= 1'b0;
    else if (state == TS_RESET || state == TS_UPD_IR)    dataPhase <= 1'b0;
    else if (state == TS_UPD_DR && drSel == DR_REGSEL)   dataPhase <= !dataPhase;
  end

  assign strb.capDr     = (state == TS_CAP_DR);
  assign strb.shfDr     = (state == TS_SHF_DR);
  assign strb.updDr     = (state == TS_UPD_DR);
  assign strb.drSel     = drSel;
  assign strb.dataPhase = dataPhase;
  assign irShifting     = (state == TS_SHF_IR);
  assign irTdo          = irShift[0];

  AST_IDCODE_AFTER_RESET: assert property (@(posedge tck) disable iff (!trstN)
    (state == TS_RESET) |=> (drSel == DR_IDCODE)); // R1
  AST_PHASE_CLR_ON_IR: assert property (@(posedge tck) disable iff (!trstN)
    (state == TS_UPD_IR) |=> !dataPhase); // R6
  AST_PHASE_HOLDS: assert property (@(posedge tck) disable iff (!trstN)
    (state == TS_SHF_DR) |=> $stable(dataPhase)); // R3

endmodule

// File: rtl/jtag_dbg_dpath.sv
module jtag_dbg_dpath
  import jtag_dbg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7,
  parameter int PWR_W  = 8,
  parameter logic [DATA_W-1:0] IDCODE = 32'h1234_5A6B
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic              tdi,
  input  tapStrobe_t        strb,
  output logic              drTdo,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic [ADDR_W-1:0] regNum,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData,
  output logic [PWR_W-1:0]  pwrCtl,
  input  logic [PWR_W-1:0]  pwrStatSet
);

  localparam int ADR_SCAN_W = ADDR_W + 1;
  localparam int LEN_W      = $clog2(DATA_W);

  logic [DATA_W-1:0] drShift, capVal, shiftNext;
  logic [LEN_W-1:0]  topIdx;
  logic [PWR_W-1:0]  pwrStat;
  logic              wrFlag;
  logic              isRegSel, pstatUpd;

  assign isRegSel = (strb.drSel == DR_REGSEL);
  assign pstatUpd = strb.updDr && (strb.drSel == DR_PSTAT);

  // Scan length per selected data register
  always_comb begin
    unique case (strb.drSel)
      DR_BYPASS: topIdx = '0;
      DR_PCTL,
      DR_PSTAT:  topIdx = LEN_W'(PWR_W - 1);
      DR_REGSEL: topIdx = strb.dataPhase ? LEN_W'(DATA_W - 1) : LEN_W'(ADR_SCAN_W - 1);
      default:   topIdx = LEN_W'(DATA_W - 1);
    endcase
  end

  always_comb begin
    unique case (strb.drSel)
      DR_IDCODE: capVal = IDCODE;
      DR_PCTL:   capVal = DATA_W'(pwrCtl);
      DR_PSTAT:  capVal = DATA_W'(pwrStat);
      DR_REGSEL: capVal = (strb.dataPhase && !wrFlag) ? regRdData : '0;
      default:   capVal = '0;
    endcase
  end

  always_comb begin
    shiftNext         = drShift >> 1;
    shiftNext[topIdx] = tdi;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)            drShift <= '0;
    else if (strb.capDr)   drShift <= capVal;
    else if (strb.shfDr)   drShift <= shiftNext;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      pwrCtl <= '0;
      regNum <= '0;
      wrFlag <= 1'b0;
    end else if (strb.updDr) begin
      if (strb.drSel == DR_PCTL) pwrCtl <= drShift[PWR_W-1:0];
      if (isRegSel && !strb.dataPhase) begin
        regNum <= drShift[ADR_SCAN_W-1:1];
        wrFlag <= drShift[0];
      end
    end
  end

  // Sticky status with clear-by-mask; a same-cycle set wins
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)        pwrStat <= '0;
    else if (pstatUpd) pwrStat <= (pwrStat & ~drShift[PWR_W-1:0]) | pwrStatSet;
    else               pwrStat <= pwrStat | pwrStatSet;
  end

  assign regWrEn   = strb.updDr && isRegSel && strb.dataPhase && wrFlag;
  assign regRdEn   = strb.capDr && isRegSel && strb.dataPhase && !wrFlag;
  assign regWrData = drShift;
  assign drTdo     = drShift[0];

  AST_WR_SINGLE: assert property (@(posedge tck) disable iff (!trstN)
    regWrEn |=> !regWrEn); // R4
  AST_NUM_HELD_IN_DATA: assert property (@(posedge tck) disable iff (!trstN)
    (isRegSel && strb.dataPhase) |=> $stable(regNum)); // R4
  AST_PCTL_HOLD: assert property (@(posedge tck) disable iff (!trstN)
    !(strb.updDr && strb.drSel == DR_PCTL) |=> $stable(pwrCtl)); // R7
  AST_PSTAT_STICKY: assert property (@(posedge tck) disable iff (!trstN)
    !pstatUpd |=> ((pwrStat & $past(pwrStat)) == $past(pwrStat))); // R8

endmodule

// File: rtl/jtag_dbg_port.sv
module jtag_dbg_port
  import jtag_dbg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7,
  parameter int PWR_W  = 8,
  parameter logic [DATA_W-1:0] IDCODE = 32'h1234_5A6B
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic [ADDR_W-1:0] regNum,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData,
  output logic [PWR_W-1:0]  pwrCtl,
  input  logic [PWR_W-1:0]  pwrStatSet
);

  tapStrobe_t strb;
  logic irShifting, irTdo, drTdo;

  jtag_dbg_ctrl u_ctrl (
    .tck        (tck),
    .trstN      (trstN),
    .tms        (tms),
    .tdi        (tdi),
    .strb       (strb),
    .irShifting (irShifting),
    .irTdo      (irTdo)
  );

  jtag_dbg_dpath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .PWR_W  (PWR_W),
    .IDCODE (IDCODE)
  ) u_dpath (
    .tck        (tck),
    .trstN      (trstN),
    .tdi        (tdi),
    .strb       (strb),
    .drTdo      (drTdo),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regNum     (regNum),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .pwrCtl     (pwrCtl),
    .pwrStatSet (pwrStatSet)
  );

  assign tdo = irShifting ? irTdo : (strb.shfDr ? drTdo : 1'b0);

endmodule

// File: tb/jtag_dbg_port_tb.sv
module jtag_dbg_port_tb;

  localparam logic [31:0] ID_EXP = 32'h1234_5A6B;

  logic tck = 1'b0, trstN = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, regWrEn, regRdEn;
  logic [6:0]  regNum;
  logic [31:0] regWrData, regRdData;
  logic [7:0]  pwrCtl;
  logic [7:0]  pwrStatSet = 8'h00;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    bit          isWr;
    logic [6:0]  num;
    logic [31:0] data;
    string       req;
  } busItem_t;
  busItem_t expQ[$];

  always #4 tck = ~tck;

  jtag_dbg_port u_dut (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regNum(regNum),
    .regWrData(regWrData), .regRdData(regRdData),
    .pwrCtl(pwrCtl), .pwrStatSet(pwrStatSet)
  );

  // Register bank model: unwritten entries read as {4{0,num}}
  logic [31:0]  bankMem [128];
  logic [127:0] bankVld;
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) bankVld <= '0;
    else if (regWrEn) begin
      bankMem[regNum] <= regWrData;
      bankVld[regNum] <= 1'b1;
    end
  end
  assign regRdData = bankVld[regNum] ? bankMem[regNum] : {4{1'b0, regNum}};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Monitor: every bus strobe must match the next expected item
  always @(negedge tck) begin
    if (trstN && (regWrEn || regRdEn)) begin
      nChecks++;
      if (expQ.size() == 0) begin
        nFails++;
        $display("FAIL R5: got unexpected strobe wr=%0b num=%0d expected none", regWrEn, regNum);
      end else begin
        busItem_t it;
        it = expQ.pop_front();
        if (regWrEn !== it.isWr || regNum !== it.num ||
            (it.isWr && regWrData !== it.data)) begin
          nFails++;
          $display("FAIL %s: got wr=%0b num=%0d data=%h expected wr=%0b num=%0d data=%h",
                   it.req, regWrEn, regNum, regWrData, it.isWr, it.num, it.data);
        end
      end
    end
  end

  task automatic pushBus(input bit isWr, input logic [6:0] num, input logic [31:0] data,
                         input string req);
    busItem_t it;
    it.isWr = isWr; it.num = num; it.data = data; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic irScan(input logic [4:0] code, output logic [4:0] got);
    got = '0;
    @(negedge tck) tms = 1'b1;
    @(negedge tck) tms = 1'b1;
    @(negedge tck) tms = 1'b0;
    @(negedge tck) tms = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge tck);
      got[i] = tdo;
      tdi = code[i];
      tms = (i == 4);
    end
    @(negedge tck) tms = 1'b1;
    @(negedge tck) tms = 1'b0;
    @(negedge tck);
  endtask

  task automatic drScan(input int n, input logic [31:0] din, output logic [31:0] got);
    got = '0;
    @(negedge tck) tms = 1'b1;
    @(negedge tck) tms = 1'b0;
    @(negedge tck) tms = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge tck);
      got[i] = tdo;
      tdi = din[i];
      tms = (i == n - 1);
    end
    @(negedge tck) tms = 1'b1;
    @(negedge tck) tms = 1'b0;
    @(negedge tck);
  endtask

  task automatic tmsReset();
    for (int i = 0; i < 5; i++) begin
      @(negedge tck) tms = 1'b1;
    end
    @(negedge tck) tms = 1'b0;
    @(negedge tck);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [4:0]  ir;
    logic [31:0] q;
    repeat (3) @(negedge tck);
    trstN = 1'b1;
    @(negedge tck) tms = 1'b0;
    @(negedge tck);
    chk("R10 tdo idle", {31'b0, tdo}, 32'h0);

    drScan(32, 32'h0, q);
    chk("R1 idcode after trst", q, ID_EXP);

    irScan(5'h1F, ir);
    chk("R2 ir capture", {27'b0, ir}, 32'h1);
    drScan(8, 32'hC5, q);
    chk("R9 bypass", q, 32'h8A);

    irScan(5'h05, ir);
    drScan(8, 32'h3B, q);
    chk("R2 unused code bypass", q, 32'h76);

    tmsReset();
    drScan(32, 32'h0, q);
    chk("R1 idcode after tms reset", q, ID_EXP);

    irScan(5'h1E, ir);
    drScan(32, 32'hFFFF_FFFF, q);
    chk("R2 idcode code", q, ID_EXP);

    // Register write then read
    irScan(5'h1C, ir);
    drScan(8, {24'b0, 7'd5, 1'b1}, q);
    chk("R3 address scan out", q, 32'h0);
    pushBus(1'b1, 7'd5, 32'hA5A5_1234, "R4");
    drScan(32, 32'hA5A5_1234, q);
    chk("R4 write scan out", q, 32'h0);

    drScan(8, {24'b0, 7'd5, 1'b0}, q);
    chk("R3 second address", q, 32'h0);
    pushBus(1'b0, 7'd5, 32'h0, "R5");
    drScan(32, 32'hFFFF_FFFF, q);
    chk("R5 read data", q, 32'hA5A5_1234);

    // Instruction reload drops a pending write
    drScan(8, {24'b0, 7'd9, 1'b1}, q);
    irScan(5'h1C, ir);
    drScan(8, {24'b0, 7'd3, 1'b0}, q);
    pushBus(1'b0, 7'd3, 32'h0, "R6");
    drScan(32, 32'h0, q);
    chk("R6 reload restarts address", q, 32'h0303_0303);
    drScan(8, {24'b0, 7'd9, 1'b0}, q);
    pushBus(1'b0, 7'd9, 32'h0, "R6");
    drScan(32, 32'h0, q);
    chk("R6 dropped write left reg", q, 32'h0909_0909);

    // Power control
    irScan(5'h08, ir);
    chk("R7 pwrCtl reset", {24'b0, pwrCtl}, 32'h0);
    drScan(8, 32'h5A, q);
    chk("R7 first scan out", q, 32'h0);
    chk("R7 pwrCtl load", {24'b0, pwrCtl}, 32'h5A);
    drScan(8, 32'h3C, q);
    chk("R7 previous value out", q, 32'h5A);
    chk("R7 pwrCtl reload", {24'b0, pwrCtl}, 32'h3C);

    // Power status
    @(negedge tck) pwrStatSet = 8'h81;
    @(negedge tck) pwrStatSet = 8'h00;
    irScan(5'h09, ir);
    drScan(8, 32'h01, q);
    chk("R8 status read", q, 32'h81);
    drScan(8, 32'h00, q);
    chk("R8 masked clear", q, 32'h80);
    drScan(8, 32'hFF, q);
    chk("R8 zero mask keeps", q, 32'h80);
    drScan(8, 32'h00, q);
    chk("R8 full clear", q, 32'h00);
    chk("R10 tdo idle end", {31'b0, tdo}, 32'h0);

    chk("R4 all strobes seen", expQ.size(), 32'h0);
    report();
  end

endmodule